// File: doc/BRIEF.md
# Sideband Mailbox Register Bridge

This block gives a host a narrow window onto many on-chip units that sit on a sideband fabric. The host sees four 32-bit words: a command word, an upper-address word, a data word and a status word. Writes to the data and upper-address words only stage values. A write to the command word is the single event that starts a fabric transaction. That transaction carries an opcode, a destination port, a full register offset and byte enables.

A write access is set up by staging the data word, then the upper-address word, then writing the command word. A read access is set up by staging the upper-address word, writing the command word, polling until the busy flag drops and then reading the data word. A read-modify-write is done as two transactions to the same port and offset: a read, then a write of the merged value.

One port number is reserved for a unit that is reached by other means. Requests to it are refused locally. Only one fabric transaction may be in flight at a time. The host can see this through the busy flag.

Top module: `sbmb_bridge`

## Requirements
- R1: A command word carries the opcode in bits 31:24, the port in bits 23:16, the low offset byte in bits 15:8 and the byte enables in bits 7:4. The bridge presents these on the fabric request and holds every request field stable while the request waits for ready.
- R2: The fabric address is the upper-address word bits 31:8 joined with command bits 15:8. The upper-address word reads back with bits 7:0 as zero.
- R3: Host word selects are 0 command, 1 upper address, 2 data, 3 status. Writes to words 1 and 2 never start a fabric request. Only a write to word 0 does.
- R4: An opcode with bit 0 set is a write: the request carries the staged data word. An opcode with bit 0 clear is a read.
- R5: Status bit 0 (busy) is 1 from the cycle after the launching write until the completion is accepted. At most one transaction is outstanding.
- R6: A command write while busy is ignored. It starts no request, leaves the command readback unchanged and sets status bit 3.
- R7: A command write to the reserved port (default 0x06) starts no request and sets status bit 2.
- R8: A completion with its error flag set sets status bit 1. That bit stays set until the host writes 1 to it. A failed read leaves the data word unchanged.
- R9: A successful read completion writes its data into the data word no later than the cycle in which busy clears.
- R10: A read followed by a write of the merged value to the same port and offset updates only the masked bits of the target register.
- R11: After reset all words read 0. Status bits 1 to 3 are cleared by writing 1. The host is always ready. A host read returns its data with a response strobe one cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hreg_valid | input | 1 | Host access request |
| hreg_ready | output | 1 | Host access accepted (always 1) |
| hreg_write | input | 1 | 1 = write, 0 = read |
| hreg_addr | input | HADDR_W | Word select |
| hreg_wdata | input | DATA_W | Host write data |
| hrsp_valid | output | 1 | Read response strobe |
| hrsp_rdata | output | DATA_W | Read response data |
| sb_req_valid | output | 1 | Fabric request valid |
| sb_req_ready | input | 1 | Fabric request accepted |
| sb_req_opc | output | 8 | Request opcode |
| sb_req_port | output | 8 | Destination port |
| sb_req_addr | output | ADDR_W | Register offset |
| sb_req_be | output | 4 | Byte enables |
| sb_req_wdata | output | DATA_W | Write data |
| sb_cpl_valid | input | 1 | Completion valid |
| sb_cpl_ready | output | 1 | Completion can be accepted |
| sb_cpl_err | input | 1 | Completion error flag |
| sb_cpl_rdata | input | DATA_W | Completion read data |

## Verification
The bench builds the bridge with its defaults: a 32-bit fabric address, the reserved-port check enabled and 0x06 as the reserved port. With the full 32-bit address, the bench can confirm that all upper offset bits reach the fabric. With the check enabled, the refusal path is reachable. The bench fabric model varies its ready hold-off and completion latency. Long latencies hold busy open so that a command write can collide with it. One port in the model always answers with an error, which exercises the sticky flag and the unchanged data word.

// File: rtl/sbmb_pkg.sv
package sbmb_pkg;

   // host word selects
   localparam logic [1:0] WSEL_CMD  = 2'd0;
   localparam logic [1:0] WSEL_XADR = 2'd1;
   localparam logic [1:0] WSEL_DATA = 2'd2;
   localparam logic [1:0] WSEL_STAT = 2'd3;

   // command word field geometry
   localparam int OPC_W   = 8;
   localparam int PORT_W  = 8;
   localparam int OFFL_W  = 8;
   localparam int BE_W    = 4;
   localparam int BE_LSB  = 4;
   localparam int OFFL_LSB = BE_LSB + BE_W;
   localparam int OFFL_LSB_R = 8;
   localparam int PORT_LSB = OFFL_LSB_R + OFFL_W;
   localparam int OPC_LSB  = PORT_LSB + PORT_W;

   // status bit positions
   localparam int ST_BUSY = 0;
   localparam int ST_FERR = 1;
   localparam int ST_DENY = 2;
   localparam int ST_COLL = 3;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_REQ  = 2'd1,
      SEQ_WAIT = 2'd2
   } seq_state_e;

   function automatic logic opc_is_write(input logic [OPC_W-1:0] opc);
      return opc[0];
   endfunction

endpackage

// File: rtl/sbmb_hostregs.sv
module sbmb_hostregs
   import sbmb_pkg::*;
#(
   parameter int HADDR_W = 2,
   parameter int DATA_W  = 32,
   parameter int XHI_W   = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hreg_valid,
   input  logic               hreg_write,
   input  logic [HADDR_W-1:0] hreg_addr,
   input  logic [DATA_W-1:0]  hreg_wdata,
   output logic               hreg_ready,
   output logic               hrsp_valid,
   output logic [DATA_W-1:0]  hrsp_rdata,
   input  logic               busy_i,
   input  logic               ferr_set_i,
   input  logic               deny_set_i,
   input  logic               coll_set_i,
   input  logic               cap_en_i,
   input  logic [DATA_W-1:0]  cap_data_i,
   output logic               cmd_wr_o,
   output logic [XHI_W-1:0]   xadr_hi_o,
   output logic [DATA_W-1:0]  data_o
);

   logic              addr_hit;
   logic [1:0]        wsel;
   logic              wr_acc;
   logic [DATA_W-1:0] cmd_q;
   logic [XHI_W-1:0]  xadr_q;
   logic [DATA_W-1:0] data_q;
   logic              ferr_q, deny_q, coll_q;
   logic              stat_wr;
   logic [DATA_W-1:0] xadr_rd;
   logic [DATA_W-1:0] stat_rd;
   logic [DATA_W-1:0] rd_mux;

   assign wsel = hreg_addr[1:0];

   generate
      if (HADDR_W > 2) begin : g_wide_addr
         assign addr_hit = ~|hreg_addr[HADDR_W-1:2];
      end else begin : g_narrow_addr
         assign addr_hit = 1'b1;
      end
   endgenerate

   assign hreg_ready = 1'b1;
   assign wr_acc     = hreg_valid & hreg_write & addr_hit;
   assign cmd_wr_o   = wr_acc & (wsel == WSEL_CMD);
   assign stat_wr    = wr_acc & (wsel == WSEL_STAT);
   assign xadr_hi_o  = xadr_q;
   assign data_o     = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         xadr_q <= '0;
         data_q <= '0;
      end else begin
         if (cmd_wr_o && !busy_i)
            cmd_q <= hreg_wdata;
         if (wr_acc && (wsel == WSEL_XADR))
            xadr_q <= hreg_wdata[OFFL_W +: XHI_W];
         if (cap_en_i)
            data_q <= cap_data_i;
         else if (wr_acc && (wsel == WSEL_DATA))
            data_q <= hreg_wdata;
      end
   end

   // sticky flags: a set in the same cycle as a clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ferr_q <= 1'b0;
         deny_q <= 1'b0;
         coll_q <= 1'b0;
      end else begin
         ferr_q <= ferr_set_i | (ferr_q & ~(stat_wr & hreg_wdata[ST_FERR]));
         deny_q <= deny_set_i | (deny_q & ~(stat_wr & hreg_wdata[ST_DENY]));
         coll_q <= coll_set_i | (coll_q & ~(stat_wr & hreg_wdata[ST_COLL]));
      end
   end

   always_comb begin
      xadr_rd = '0;
      xadr_rd[OFFL_W +: XHI_W] = xadr_q;
      stat_rd = '0;
      stat_rd[ST_BUSY] = busy_i;
      stat_rd[ST_FERR] = ferr_q;
      stat_rd[ST_DENY] = deny_q;
      stat_rd[ST_COLL] = coll_q;
      unique case (wsel)
         WSEL_CMD:  rd_mux = cmd_q;
         WSEL_XADR: rd_mux = xadr_rd;
         WSEL_DATA: rd_mux = data_q;
         default:   rd_mux = stat_rd;
      endcase
      if (!addr_hit)
         rd_mux = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hrsp_valid <= 1'b0;
         hrsp_rdata <= '0;
      end else begin
         hrsp_valid <= hreg_valid & ~hreg_write;
         if (hreg_valid && !hreg_write)
            hrsp_rdata <= rd_mux;
      end
   end

   // R9: captured completion data lands in the data word
   p_rdcap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en_i |=> data_q == $past(cap_data_i));

   // R8: error flag survives until explicitly cleared
   p_ferr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ferr_q && !(stat_wr && hreg_wdata[ST_FERR]) |=> ferr_q);

   // R6: a command write during busy does not replace the command readback
   p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> $stable(cmd_q));

endmodule

// File: rtl/sbmb_launch.sv
module sbmb_launch
   import sbmb_pkg::*;
#(
   parameter bit               RSV_EN   = 1'b1,
   parameter logic [PORT_W-1:0] RSV_PORT = 8'h06
) (
   input  logic              cmd_wr_i,
   input  logic              busy_i,
   input  logic [PORT_W-1:0] port_i,
   output logic              start_o,
   output logic              deny_o,
   output logic              coll_o
);

   logic is_rsv;

   generate
      if (RSV_EN) begin : g_rsv_check
         assign is_rsv = (port_i == RSV_PORT);
      end else begin : g_rsv_none
         assign is_rsv = 1'b0;
      end
   endgenerate

   assign coll_o  = cmd_wr_i & busy_i;
   assign deny_o  = cmd_wr_i & ~busy_i & is_rsv;
   assign start_o = cmd_wr_i & ~busy_i & ~is_rsv;

endmodule

// File: rtl/sbmb_seq.sv
module sbmb_seq
   import sbmb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [OPC_W-1:0]  opc_i,
   input  logic [PORT_W-1:0] port_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BE_W-1:0]   be_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              sb_req_valid,
   input  logic              sb_req_ready,
   output logic [OPC_W-1:0]  sb_req_opc,
   output logic [PORT_W-1:0] sb_req_port,
   output logic [ADDR_W-1:0] sb_req_addr,
   output logic [BE_W-1:0]   sb_req_be,
   output logic [DATA_W-1:0] sb_req_wdata,
   input  logic              sb_cpl_valid,
   output logic              sb_cpl_ready,
   input  logic              sb_cpl_err,
   input  logic [DATA_W-1:0] sb_cpl_rdata,
   output logic              busy_o,
   output logic              cap_en_o,
   output logic [DATA_W-1:0] cap_data_o,
   output logic              ferr_o
);

   seq_state_e        state;
   logic [OPC_W-1:0]  opc_q;
   logic [PORT_W-1:0] port_q;
   logic [ADDR_W-1:0] addr_q;
   logic [BE_W-1:0]   be_q;
   logic [DATA_W-1:0] wdata_q;
   logic              cpl_take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SEQ_IDLE;
         opc_q   <= '0;
         port_q  <= '0;
         addr_q  <= '0;
         be_q    <= '0;
         wdata_q <= '0;
      end else begin
         unique case (state)
            SEQ_IDLE: if (start_i) begin
               state   <= SEQ_REQ;
               opc_q   <= opc_i;
               port_q  <= port_i;
               addr_q  <= addr_i;
               be_q    <= be_i;
               wdata_q <= wdata_i;
            end
            SEQ_REQ:  if (sb_req_ready) state <= SEQ_WAIT;
            SEQ_WAIT: if (sb_cpl_valid) state <= SEQ_IDLE;
            default:  state <= SEQ_IDLE;
         endcase
      end
   end

   assign sb_req_valid = (state == SEQ_REQ);
   assign sb_cpl_ready = (state == SEQ_WAIT);
   assign sb_req_opc   = opc_q;
   assign sb_req_port  = port_q;
   assign sb_req_addr  = addr_q;
   assign sb_req_be    = be_q;
   assign sb_req_wdata = wdata_q;
   assign busy_o       = (state != SEQ_IDLE);

   assign cpl_take   = sb_cpl_ready & sb_cpl_valid;
   assign cap_en_o   = cpl_take & ~opc_is_write(opc_q) & ~sb_cpl_err;
   assign cap_data_o = sb_cpl_rdata;
   assign ferr_o     = cpl_take & sb_cpl_err;

   // R1: request fields frozen while the fabric withholds ready
   p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sb_req_valid && !sb_req_ready |=> sb_req_valid && $stable(sb_req_addr)
         && $stable(sb_req_opc) && $stable(sb_req_port) && $stable(sb_req_wdata));

   // R5: busy persists until the completion is taken
   p_busy_until_cpl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !(sb_cpl_valid && sb_cpl_ready) |=> busy_o);

   // R5: a completion never overlaps a pending request
   p_single_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sb_cpl_ready |-> !sb_req_valid);

endmodule

// File: rtl/sbmb_bridge.sv
module sbmb_bridge
   import sbmb_pkg::*;
#(
   parameter int          HADDR_W  = 2,
   parameter int          DATA_W   = 32,
   parameter int          ADDR_W   = 32,
   parameter bit          RSV_EN   = 1'b1,
   parameter logic [7:0]  RSV_PORT = 8'h06
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hreg_valid,
   output logic               hreg_ready,
   input  logic               hreg_write,
   input  logic [HADDR_W-1:0] hreg_addr,
   input  logic [DATA_W-1:0]  hreg_wdata,
   output logic               hrsp_valid,
   output logic [DATA_W-1:0]  hrsp_rdata,
   output logic               sb_req_valid,
   input  logic               sb_req_ready,
   output logic [7:0]         sb_req_opc,
   output logic [7:0]         sb_req_port,
   output logic [ADDR_W-1:0]  sb_req_addr,
   output logic [3:0]         sb_req_be,
   output logic [DATA_W-1:0]  sb_req_wdata,
   input  logic               sb_cpl_valid,
   output logic               sb_cpl_ready,
   input  logic               sb_cpl_err,
   input  logic [DATA_W-1:0]  sb_cpl_rdata
);

   localparam int XHI_W = ADDR_W - OFFL_W;

   generate
      if (DATA_W != 32) begin : g_bad_data_w
         $error("sbmb_bridge: DATA_W must be 32");
      end
      if (ADDR_W <= OFFL_W || ADDR_W > DATA_W) begin : g_bad_addr_w
         $error("sbmb_bridge: ADDR_W must lie in 9..DATA_W");
      end
      if (HADDR_W < 2) begin : g_bad_haddr_w
         $error("sbmb_bridge: HADDR_W must be at least 2");
      end
   endgenerate

   logic              busy;
   logic              cmd_wr;
   logic              start, deny, coll;
   logic              ferr_set, cap_en;
   logic [DATA_W-1:0] cap_data;
   logic [XHI_W-1:0]  xadr_hi;
   logic [DATA_W-1:0] data_word;
   logic [ADDR_W-1:0] full_addr;

   assign full_addr = {xadr_hi, hreg_wdata[OFFL_LSB_R +: OFFL_W]};

   sbmb_hostregs #(
      .HADDR_W (HADDR_W),
      .DATA_W  (DATA_W),
      .XHI_W   (XHI_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .hreg_valid (hreg_valid),
      .hreg_write (hreg_write),
      .hreg_addr  (hreg_addr),
      .hreg_wdata (hreg_wdata),
      .hreg_ready (hreg_ready),
      .hrsp_valid (hrsp_valid),
      .hrsp_rdata (hrsp_rdata),
      .busy_i     (busy),
      .ferr_set_i (ferr_set),
      .deny_set_i (deny),
      .coll_set_i (coll),
      .cap_en_i   (cap_en),
      .cap_data_i (cap_data),
      .cmd_wr_o   (cmd_wr),
      .xadr_hi_o  (xadr_hi),
      .data_o     (data_word)
   );

   sbmb_launch #(
      .RSV_EN   (RSV_EN),
      .RSV_PORT (RSV_PORT)
   ) u_launch (
      .cmd_wr_i (cmd_wr),
      .busy_i   (busy),
      .port_i   (hreg_wdata[PORT_LSB +: PORT_W]),
      .start_o  (start),
      .deny_o   (deny),
      .coll_o   (coll)
   );

   sbmb_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start),
      .opc_i        (hreg_wdata[OPC_LSB +: OPC_W]),
      .port_i       (hreg_wdata[PORT_LSB +: PORT_W]),
      .addr_i       (full_addr),
      .be_i         (hreg_wdata[BE_LSB +: BE_W]),
      .wdata_i      (data_word),
      .sb_req_valid (sb_req_valid),
      .sb_req_ready (sb_req_ready),
      .sb_req_opc   (sb_req_opc),
      .sb_req_port  (sb_req_port),
      .sb_req_addr  (sb_req_addr),
      .sb_req_be    (sb_req_be),
      .sb_req_wdata (sb_req_wdata),
      .sb_cpl_valid (sb_cpl_valid),
      .sb_cpl_ready (sb_cpl_ready),
      .sb_cpl_err   (sb_cpl_err),
      .sb_cpl_rdata (sb_cpl_rdata),
      .busy_o       (busy),
      .cap_en_o     (cap_en),
      .cap_data_o   (cap_data),
      .ferr_o       (ferr_set)
   );

   // R3: a new fabric request follows only a command-word write
   p_launch_on_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sb_req_valid) |-> $past(hreg_valid && hreg_write && hreg_addr == HADDR_W'(WSEL_CMD)));

   generate
      if (RSV_EN) begin : g_rsv_assert
         // R7: the reserved port never reaches the fabric
         p_no_rsv_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
            sb_req_valid |-> sb_req_port != RSV_PORT);
      end
   endgenerate

endmodule

// File: tb/test_sbmb_bridge.sv
module test_sbmb_bridge;

   localparam logic [7:0] P_RSV = 8'h06;
   localparam logic [7:0] P_ERR = 8'h2A;
   localparam logic [7:0] OP_RD = 8'h10;
   localparam logic [7:0] OP_WR = 8'h11;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        hreg_valid, hreg_ready, hreg_write;
   logic [1:0]  hreg_addr;
   logic [31:0] hreg_wdata;
   logic        hrsp_valid;
   logic [31:0] hrsp_rdata;
   logic        sb_req_valid, sb_req_ready;
   logic [7:0]  sb_req_opc, sb_req_port;
   logic [31:0] sb_req_addr;
   logic [3:0]  sb_req_be;
   logic [31:0] sb_req_wdata;
   logic        sb_cpl_valid, sb_cpl_ready, sb_cpl_err;
   logic [31:0] sb_cpl_rdata;

   always #4 clk = ~clk;

   sbmb_bridge i_sbmb_bridge (
      .clk(clk), .rst_n(rst_n),
      .hreg_valid(hreg_valid), .hreg_ready(hreg_ready), .hreg_write(hreg_write),
      .hreg_addr(hreg_addr), .hreg_wdata(hreg_wdata),
      .hrsp_valid(hrsp_valid), .hrsp_rdata(hrsp_rdata),
      .sb_req_valid(sb_req_valid), .sb_req_ready(sb_req_ready),
      .sb_req_opc(sb_req_opc), .sb_req_port(sb_req_port), .sb_req_addr(sb_req_addr),
      .sb_req_be(sb_req_be), .sb_req_wdata(sb_req_wdata),
      .sb_cpl_valid(sb_cpl_valid), .sb_cpl_ready(sb_cpl_ready),
      .sb_cpl_err(sb_cpl_err), .sb_cpl_rdata(sb_cpl_rdata)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   // fabric model state
   logic [31:0] fab_mem [64];
   logic [31:0] exp_mem [64];
   int          fab_lat = 2;
   int          fab_hold = 0;
   int          req_cnt = 0;
   logic [7:0]  last_opc, last_port;
   logic [31:0] last_addr, last_wdata;
   logic [3:0]  last_be;

   function automatic int fidx(input logic [7:0] p, input logic [31:0] a);
      return int'({p[1:0], a[3:0]});
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic host_wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      hreg_valid = 1'b1; hreg_write = 1'b1; hreg_addr = a; hreg_wdata = d;
      @(negedge clk);
      hreg_valid = 1'b0; hreg_write = 1'b0;
   endtask

   task automatic host_rd(input logic [1:0] a, output logic [31:0] d, output logic ok);
      @(negedge clk);
      hreg_valid = 1'b1; hreg_write = 1'b0; hreg_addr = a;
      @(negedge clk);
      hreg_valid = 1'b0;
      ok = hrsp_valid;
      d  = hrsp_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      logic ok;
      for (int i = 0; i < 400; i++) begin
         host_rd(2'd3, s, ok);
         if (!s[0]) break;
      end
   endtask

   function automatic logic [31:0] cmd(input logic [7:0] op, input logic [7:0] p,
                                       input logic [31:0] off, input logic [3:0] be);
      return {op, p, off[7:0], be, 4'h0};
   endfunction

   task automatic do_write(input logic [7:0] p, input logic [31:0] off, input logic [31:0] v);
      host_wr(2'd2, v);
      host_wr(2'd1, off & 32'hFFFF_FF00);
      host_wr(2'd0, cmd(OP_WR, p, off, 4'hF));
      wait_idle();
      if (p != P_ERR && p != P_RSV) exp_mem[fidx(p, off)] = v;
   endtask

   task automatic do_read(input logic [7:0] p, input logic [31:0] off, output logic [31:0] v);
      logic ok;
      host_wr(2'd1, off & 32'hFFFF_FF00);
      host_wr(2'd0, cmd(OP_RD, p, off, 4'hF));
      wait_idle();
      host_rd(2'd2, v, ok);
   endtask

   // fabric responder
   initial begin
      logic        err;
      logic [31:0] rd;
      int          ix;
      sb_req_ready = 1'b0; sb_cpl_valid = 1'b0; sb_cpl_err = 1'b0; sb_cpl_rdata = '0;
      forever begin
         @(negedge clk);
         if (sb_req_valid === 1'b1) begin
            repeat (fab_hold) @(negedge clk);
            sb_req_ready = 1'b1;
            last_opc = sb_req_opc; last_port = sb_req_port; last_addr = sb_req_addr;
            last_be = sb_req_be; last_wdata = sb_req_wdata;
            req_cnt++;
            ix  = fidx(sb_req_port, sb_req_addr);
            err = (sb_req_port == P_ERR);
            rd  = fab_mem[ix];
            if (sb_req_opc[0] && !err) fab_mem[ix] = sb_req_wdata;
            @(negedge clk);
            sb_req_ready = 1'b0;
            repeat (fab_lat) @(negedge clk);
            sb_cpl_valid = 1'b1; sb_cpl_err = err;
            sb_cpl_rdata = err ? 32'hDEAD_BEEF : rd;
            @(negedge clk);
            sb_cpl_valid = 1'b0; sb_cpl_err = 1'b0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      logic [31:0] v, s, first_cmd, mrg;
      logic ok;
      int c0;
      for (int i = 0; i < 64; i++) begin
         fab_mem[i] = (i * 32'h0101_0101) ^ 32'hA5A5_0000;
         exp_mem[i] = fab_mem[i];
      end
      hreg_valid = 0; hreg_write = 0; hreg_addr = 0; hreg_wdata = 0;
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R11: reset values, ready, response timing
      host_rd(2'd3, s, ok);
      chk("R11 status after reset", s, 32'h0);
      chk("R11 read strobe", {31'd0, ok}, 32'd1);
      chk("R11 host ready", {31'd0, hreg_ready}, 32'd1);
      host_rd(2'd0, v, ok);
      chk("R11 command after reset", v, 32'h0);
      host_rd(2'd2, v, ok);
      chk("R11 data after reset", v, 32'h0);

      // R3: staging writes do not launch
      c0 = req_cnt;
      host_wr(2'd2, 32'h1357_9BDF);
      host_wr(2'd1, 32'h0000_12FF);
      repeat (10) @(negedge clk);
      chk("R3 staging launches nothing", req_cnt, c0);
      host_rd(2'd1, v, ok);
      chk("R2 upper address readback", v, 32'h0000_1200);

      // R1 R2 R4: write transaction fields
      host_wr(2'd0, {OP_WR, 8'h01, 8'h34, 4'hA, 4'h0});
      wait_idle();
      chk("R3 command launches one", req_cnt, c0 + 1);
      chk("R1 opcode", {24'd0, last_opc}, {24'd0, OP_WR});
      chk("R1 port", {24'd0, last_port}, 32'h01);
      chk("R1 byte enables", {28'd0, last_be}, 32'hA);
      chk("R2 full address", last_addr, 32'h0000_1234);
      chk("R4 write data", last_wdata, 32'h1357_9BDF);
      exp_mem[fidx(8'h01, 32'h1234)] = 32'h1357_9BDF;

      // R5 R6: busy and collision
      fab_lat = 30;
      c0 = req_cnt;
      first_cmd = cmd(OP_RD, 8'h02, 32'h0000_0005, 4'hF);
      host_wr(2'd1, 32'h0);
      host_wr(2'd0, first_cmd);
      host_rd(2'd3, s, ok);
      chk("R5 busy while outstanding", {31'd0, s[0]}, 32'd1);
      host_wr(2'd0, cmd(OP_WR, 8'h03, 32'h0000_0007, 4'hF));
      host_rd(2'd3, s, ok);
      chk("R6 collision flag", {31'd0, s[3]}, 32'd1);
      host_rd(2'd0, v, ok);
      chk("R6 command readback kept", v, first_cmd);
      wait_idle();
      fab_lat = 2;
      chk("R6 no extra request", req_cnt, c0 + 1);
      chk("R6 in-flight port kept", {24'd0, last_port}, 32'h02);
      host_rd(2'd2, v, ok);
      chk("R9 read data captured", v, exp_mem[fidx(8'h02, 32'h5)]);
      host_wr(2'd3, 32'h8);
      host_rd(2'd3, s, ok);
      chk("R11 collision cleared by W1C", s, 32'h0);

      // R7: reserved port
      c0 = req_cnt;
      host_wr(2'd0, cmd(OP_RD, P_RSV, 32'h10, 4'hF));
      repeat (8) @(negedge clk);
      chk("R7 reserved port no request", req_cnt, c0);
      host_rd(2'd3, s, ok);
      chk("R7 deny flag, not busy", s, 32'h4);
      host_wr(2'd3, 32'h4);
      host_rd(2'd3, s, ok);
      chk("R7 deny cleared", s, 32'h0);

      // R8: error completion
      host_wr(2'd2, 32'h0BAD_0001);
      do_read(P_ERR, 32'h20, v);
      chk("R8 data unchanged after failed read", v, 32'h0BAD_0001);
      host_rd(2'd3, s, ok);
      chk("R8 error flag set", s, 32'h2);
      host_wr(2'd3, 32'h0);
      host_rd(2'd3, s, ok);
      chk("R8 error flag sticky", s, 32'h2);
      host_wr(2'd3, 32'h2);
      host_rd(2'd3, s, ok);
      chk("R8 error flag cleared", s, 32'h0);

      // R10: read-modify-write
      do_read(8'h01, 32'h1234, v);
      chk("R10 rmw read", v, exp_mem[fidx(8'h01, 32'h1234)]);
      mrg = (v & ~32'h00FF_FF00) | (32'hCAFE_BABE & 32'h00FF_FF00);
      do_write(8'h01, 32'h1234, mrg);
      do_read(8'h01, 32'h1234, v);
      chk("R10 rmw result", v, mrg);

      // random mix
      void'($urandom(32'h0005_EED1));
      for (int k = 0; k < 60; k++) begin
         logic [7:0]  p;
         logic [31:0] off, d;
         p        = 8'($urandom_range(0, 3));
         off      = $urandom & 32'h0000_0FFF;
         fab_lat  = $urandom_range(0, 4);
         fab_hold = $urandom_range(0, 3);
         if ($urandom_range(0, 1) == 1) begin
            d = $urandom;
            do_write(p, off, d);
            chk("R4 random write address", last_addr, off);
         end else begin
            do_read(p, off, d);
            chk("R9 random read", d, exp_mem[fidx(p, off)]);
         end
      end
      finish_run();
   end

endmodule